// File: doc/BRIEF.md
# Bidirectional Row-Scan Shift Register

This block is the row-side logic of a dot-matrix display driver. A chain of row flags, 240 by default, advances by one stage on every falling edge of the line pulse, so the timing controller walks a select token down the panel one row per line. The shift direction is set by a direction input. A split input picks between one long chain and two independent half-length chains. In split mode the second half is fed from a separate data input, so two panel halves can be scanned at the same time.

The two chain ends are bidirectional pins. The upstream pin is read as the scan input. The downstream pin carries the last stage out, so several drivers can be cascaded. For every row the block produces a registered 2-bit drive-level code. The code depends on the row flag and on the frame-inversion input. An active-low blanking input empties the chain and forces every row to the ground code. The block runs on a system clock and samples the line pulse as an ordinary input.

Top module: `rowscan_drv`

## Requirements
- R1: While `rst` is high, the chain is emptied and every 2-bit row code in `level_o` is 2'b00. After release, with `blank_n` high and `fr` high, every row reads the unselected code 2'b01.
- R2: The chain moves exactly one stage on each clock edge where `lp` is low and was high at the previous edge. At any other edge the chain is unchanged. A rising edge of `lp`, or `lp` held at either level, has no effect on `level_o`.
- R3: In single mode (`split`=0) with `dir`=1, stage 0 takes `end_a`, stage i takes stage i-1, and stage 239 appears on `end_b`. A one entered at `end_a` reaches `end_b` on the 240th falling edge.
- R4: In single mode with `dir`=0, stage 239 takes `end_b`, stage i takes stage i+1, and stage 0 appears on `end_a`.
- R5: In split mode with `dir`=1, stage 120 takes `mid_in` instead of stage 119. The rest of the chain moves as in R3.
- R6: In split mode with `dir`=0, stage 119 takes `mid_in` instead of stage 120. The rest of the chain moves as in R4.
- R7: The downstream end pin (`end_b` when `dir`=1, `end_a` when `dir`=0) is driven by the block with the last stage's value. The other end pin is released so that it can act as the input.
- R8: At a clock edge where `blank_n` is low, the chain is cleared and every row code becomes 2'b00. After `blank_n` returns high, all rows stay unselected until new data is shifted in.
- R9: One clock after the chain or `fr` changes, row r's code is at bits [2r+1:2r] of `level_o`. The codes are: selected with `fr`=1 gives 2'b11, selected with `fr`=0 gives 2'b00, unselected with `fr`=1 gives 2'b01, unselected with `fr`=0 gives 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lp | input | 1 | Line pulse; its falling edge shifts the chain |
| dir | input | 1 | 1: shift toward higher stages; 0: toward lower stages |
| split | input | 1 | 0: one full chain; 1: two half chains |
| mid_in | input | 1 | Scan input of the second half chain in split mode |
| fr | input | 1 | Frame-inversion input |
| blank_n | input | 1 | Active-low blanking; clears the chain and grounds all rows |
| end_a | inout | 1 | Low-stage end pin: input when dir=1, output when dir=0 |
| end_b | inout | 1 | High-stage end pin: input when dir=0, output when dir=1 |
| level_o | output | 480 | Registered 2-bit level code per row, row r at [2r+1:2r] |

## Verification
The hardest case to reach is the seam between the two halves in split mode. The two stages that meet there only show a difference after a token has crossed 120 stages and the direction or mode has been changed on a chain that still holds data. The stimulus gets there in two ways. Directed runs push tokens the full length of each half in both directions. Random runs then flip `dir`, `split` and the end-pin data between single falling edges. A bench model of the chain predicts every row code after every step. Blanking pulses are placed among the shifts, so that clearing is also seen on a partly filled chain.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

  typedef enum logic [1:0] {
    LV_LOW     = 2'b00,
    LV_MIDLOW  = 2'b01,
    LV_MIDHIGH = 2'b10,
    LV_HIGH    = 2'b11
  } level_e;

  function automatic logic [1:0] row_code(input logic sel, input logic fr);
    level_e v;
    if (sel) v = fr ? LV_HIGH : LV_LOW;
    else     v = fr ? LV_MIDLOW : LV_MIDHIGH;
    return v;
  endfunction

endpackage

// File: rtl/rs_edge.sv
module rs_edge (
  input  logic clk,
  input  logic rst,
  input  logic lp,
  output logic fall_o
);
  logic lp_q;

  always_ff @(posedge clk) begin
    if (rst) lp_q <= 1'b0;
    else     lp_q <= lp;
  end

  assign fall_o = lp_q & ~lp;
endmodule

// File: rtl/rs_chain.sv
module rs_chain #(
  parameter int STAGES = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              dir,
  input  logic              split,
  input  logic              in_lo,
  input  logic              in_hi,
  input  logic              in_mid,
  output logic [STAGES-1:0] q
);
  localparam int HALF = STAGES / 2;

  logic [STAGES-1:0] up_src;
  logic [STAGES-1:0] dn_src;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_lo_end
      assign up_src[i] = in_lo;
    end else if (i == HALF) begin : g_seam_up
      assign up_src[i] = split ? in_mid : q[i-1];
    end else begin : g_up
      assign up_src[i] = q[i-1];
    end

    if (i == STAGES-1) begin : g_hi_end
      assign dn_src[i] = in_hi;
    end else if (i == HALF-1) begin : g_seam_dn
      assign dn_src[i] = split ? in_mid : q[i+1];
    end else begin : g_dn
      assign dn_src[i] = q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (shift)  q <= dir ? up_src : dn_src;
  end
endmodule

// File: rtl/rs_level.sv
module rs_level #(
  parameter int ROWS = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blank_n,
  input  logic              fr,
  input  logic [ROWS-1:0]   sel,
  output logic [2*ROWS-1:0] code
);
  import rowscan_pkg::*;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst || !blank_n) code[2*r +: 2] <= LV_LOW;
      else                 code[2*r +: 2] <= row_code(sel[r], fr);
    end
  end
endmodule

// File: rtl/rowscan_drv.sv
module rowscan_drv #(
  parameter int STAGES = 240
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lp,
  input  logic                dir,
  input  logic                split,
  input  logic                mid_in,
  input  logic                fr,
  input  logic                blank_n,
  inout  wire                 end_a,
  inout  wire                 end_b,
  output logic [2*STAGES-1:0] level_o
);
  logic              shift;
  logic [STAGES-1:0] q;

  rs_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lp     (lp),
    .fall_o (shift)
  );

  rs_chain #(.STAGES(STAGES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .clr    (!blank_n),
    .shift  (shift),
    .dir    (dir),
    .split  (split),
    .in_lo  (end_a),
    .in_hi  (end_b),
    .in_mid (mid_in),
    .q      (q)
  );

  rs_level #(.ROWS(STAGES)) u_level (
    .clk     (clk),
    .rst     (rst),
    .blank_n (blank_n),
    .fr      (fr),
    .sel     (q),
    .code    (level_o)
  );

  assign end_b = dir  ? q[STAGES-1] : 1'bz;
  assign end_a = !dir ? q[0]        : 1'bz;
endmodule

// File: rtl/rowscan_chk.sv
module rowscan_chk #(
  parameter int STAGES = 240
) (
  input logic                clk,
  input logic                rst,
  input logic                lp,
  input logic                dir,
  input logic                split,
  input logic                mid_in,
  input logic                fr,
  input logic                blank_n,
  input logic                end_a,
  input logic                end_b,
  input logic [STAGES-1:0]   q,
  input logic [2*STAGES-1:0] level_o
);
  import rowscan_pkg::*;
  localparam int HALF = STAGES / 2;

  logic lp_seen;
  logic fell;

  always_ff @(posedge clk) begin
    if (rst) lp_seen <= 1'b0;
    else     lp_seen <= lp;
  end
  assign fell = lp_seen && !lp;

  // R2: no falling edge, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!fell && blank_n) |=> $stable(q));

  // R3: single chain, upward entry at the low end pin
  a_r3_entry: assert property (@(posedge clk) disable iff (rst)
    (fell && blank_n && !split && dir) |=> (q[0] == $past(end_a)));

  // R4: single chain, downward entry at the high end pin
  a_r4_entry: assert property (@(posedge clk) disable iff (rst)
    (fell && blank_n && !split && !dir) |=> (q[STAGES-1] == $past(end_b)));

  // R5: split upward, second half fed from mid_in
  a_r5_seam: assert property (@(posedge clk) disable iff (rst)
    (fell && blank_n && split && dir) |=> (q[HALF] == $past(mid_in)));

  // R6: split downward, first half fed from mid_in
  a_r6_seam: assert property (@(posedge clk) disable iff (rst)
    (fell && blank_n && split && !dir) |=> (q[HALF-1] == $past(mid_in)));

  // R8: blanking clears chain and grounds rows
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> (q == '0 && level_o == '0));

  // R9: row 0 code follows flag and fr one clock later
  a_r9_code: assert property (@(posedge clk) disable iff (rst)
    blank_n |=> (level_o[1:0] == row_code($past(q[0]), $past(fr))));
endmodule

bind rowscan_drv rowscan_chk #(.STAGES(STAGES)) u_rowscan_chk (
  .clk     (clk),
  .rst     (rst),
  .lp      (lp),
  .dir     (dir),
  .split   (split),
  .mid_in  (mid_in),
  .fr      (fr),
  .blank_n (blank_n),
  .end_a   (end_a),
  .end_b   (end_b),
  .q       (q),
  .level_o (level_o)
);

// File: tb/rowscan_drv_bench.sv
module rowscan_drv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 240;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst, lp, dir, split, mid_in, fr, blank_n;
  logic a_drv, b_drv;
  wire  end_a, end_b;
  logic [2*N-1:0] level_o;

  logic [N-1:0] m;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign end_a = dir  ? a_drv : 1'bz;
  assign end_b = !dir ? b_drv : 1'bz;

  rowscan_drv #(.STAGES(N)) u_rowscan_drv (
    .clk(clk), .rst(rst), .lp(lp), .dir(dir), .split(split),
    .mid_in(mid_in), .fr(fr), .blank_n(blank_n),
    .end_a(end_a), .end_b(end_b), .level_o(level_o)
  );

  function automatic logic [1:0] want_code(input logic sel, input logic f);
    if (sel) return f ? 2'b11 : 2'b00;
    return f ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [2*N-1:0] want_levels(input logic [N-1:0] s,
                                                 input logic f, input logic bn);
    logic [2*N-1:0] v;
    for (int r = 0; r < N; r++) v[2*r +: 2] = bn ? want_code(s[r], f) : 2'b00;
    return v;
  endfunction

  function automatic logic [N-1:0] model_step(input logic [N-1:0] s,
      input logic d, input logic sp, input logic ia, input logic ib, input logic im);
    logic [N-1:0] n;
    if (d) begin
      n = {s[N-2:0], ia};
      if (sp) n[H] = im;
    end else begin
      n = {ib, s[N-1:1]};
      if (sp) n[H-1] = im;
    end
    return n;
  endfunction

  task automatic check_all(input string tag);
    logic [2*N-1:0] exp_l;
    logic exp_pin, got_pin;
    exp_l = want_levels(m, fr, blank_n);
    checks++;
    if (level_o !== exp_l) begin
      fails++;
      $display("FAIL %s level_o actual=%h expected=%h", tag, level_o, exp_l);
    end
    exp_pin = dir ? m[N-1] : m[0];
    got_pin = dir ? end_b : end_a;
    checks++;
    if (got_pin !== exp_pin) begin
      fails++;
      $display("FAIL %s R7 end pin actual=%b expected=%b", tag, got_pin, exp_pin);
    end
  endtask

  // one falling line-pulse edge with given inputs, then check
  task automatic fall_step(input logic d, input logic sp, input logic ia,
                           input logic ib, input logic im, input string tag);
    dir = d; split = sp; a_drv = ia; b_drv = ib; mid_in = im;
    lp = 1'b0;
    @(negedge clk);
    m = model_step(m, d, sp, ia, ib, im);
    @(negedge clk);
    check_all(tag);
    lp = 1'b1;
    @(negedge clk);
  endtask

  task automatic blank_pulse(input string tag);
    blank_n = 1'b0;
    @(negedge clk);
    m = '0;
    @(negedge clk);
    check_all(tag);
    blank_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [2*N-1:0] snap;
    void'($urandom(32'd4711));
    rst = 1'b1; lp = 1'b1; dir = 1'b1; split = 1'b0; mid_in = 1'b0;
    fr = 1'b1; blank_n = 1'b1; a_drv = 1'b0; b_drv = 1'b0;
    m = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (level_o !== '0) begin
      fails++;
      $display("FAIL R1 level_o in reset actual=%h expected=0", level_o);
    end
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_all("R1");

    // R3 full single upward run: one token, 239 zeros
    fall_step(1, 0, 1, 0, 0, "R3");
    for (int k = 1; k < N; k++) fall_step(1, 0, 0, 0, 0, "R3");
    checks++;
    if (end_b !== 1'b1) begin
      fails++;
      $display("FAIL R3 token at end_b actual=%b expected=1", end_b);
    end

    // R9 code under both fr polarities with token at row 239
    fr = 1'b0;
    @(negedge clk); @(negedge clk);
    check_all("R9");
    fr = 1'b1;
    @(negedge clk); @(negedge clk);
    check_all("R9");

    // R2 holding lp or raising it does nothing
    snap = level_o;
    lp = 1'b1; a_drv = 1'b1;
    repeat (4) @(negedge clk);
    lp = 1'b0; @(negedge clk);
    m = model_step(m, 1, 0, 1, 0, 0);
    lp = 1'b0; repeat (3) @(negedge clk);
    check_all("R2");
    lp = 1'b1; repeat (3) @(negedge clk);
    check_all("R2");
    checks++;
    if (level_o === snap) begin
      fails++;
      $display("FAIL R2 single fall produced no move actual=%h expected change", level_o);
    end

    // R8 blanking on a partly filled chain
    blank_pulse("R8");

    // R4 downward single run
    fall_step(0, 0, 0, 1, 0, "R4");
    for (int k = 1; k < N; k++) fall_step(0, 0, 0, 0, 0, "R4");
    checks++;
    if (end_a !== 1'b1) begin
      fails++;
      $display("FAIL R4 token at end_a actual=%b expected=1", end_a);
    end
    blank_pulse("R8");

    // R5 split upward: two tokens in parallel halves
    fall_step(1, 1, 1, 0, 1, "R5");
    for (int k = 1; k < H + 3; k++) fall_step(1, 1, 0, 0, 0, "R5");
    blank_pulse("R8");

    // R6 split downward
    fall_step(0, 1, 0, 1, 1, "R6");
    for (int k = 1; k < H + 3; k++) fall_step(0, 1, 0, 0, 0, "R6");

    // random mix of all modes
    for (int k = 0; k < 1500; k++) begin
      logic [7:0] rr;
      rr = 8'($urandom);
      if (rr < 8'd6) blank_pulse("R8");
      else begin
        fr = $urandom % 2;
        fall_step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  $urandom % 2, "R9");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule